// File: doc/BRIEF.md
# Pairwise Widening Add-Accumulate Unit

This unit decodes one 32-bit vector instruction of the pairwise add-long kind and executes it on a 64-bit or 128-bit source vector. Each pair of neighbouring source elements is summed into one element twice as wide. The sum is taken as signed (sign-extended) or as unsigned (zero-extended). In the accumulate variant, each widened sum is then added to the matching element of the current destination vector, with wraparound at the doubled width. A separate input picks the accumulate variant, because both variants share the same encoding layout.

The request (instruction word, variant select, source vector and destination vector) arrives on a valid/ready input. The result arrives on a valid/ready output, together with a write enable, an undefined-instruction flag, a match flag and the full destination and source register indices. A one-entry output register sits between the two sides. A request is taken when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the output register is empty, or when it is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output field holds its value.

Top module: `pwadd_unit`

## Requirements
- R1: A word matches only when bits [31:23]=111100111, [21:20]=11, [17:16]=00, [11:8]=0110 and [4]=0. A word that does not match gives `out_match`=0, `out_undef`=0 and `out_wr_en`=0. The result is all zeros whenever `out_wr_en` is low.
- R2: `out_rd_idx` is {insn[22], insn[15:12]}, `out_rs_idx` is {insn[5], insn[3:0]}, and `out_quad` is insn[6] (1 selects 128-bit operands).
- R3: A matching word with size field insn[19:18]=11 raises `out_undef`, and `out_wr_en` stays 0.
- R4: A matching word with insn[6]=1 and insn[12]=1 or insn[0]=1 raises `out_undef`, and `out_wr_en` stays 0. With insn[6]=0 these index bits do not cause an undefined result.
- R5: With insn[7]=1, the source element width is 8<<size. Output lane i, at twice that width, is the zero-extended sum of source lanes 2i and 2i+1.
- R6: With insn[7]=0, the lane sums are formed from sign-extended elements, so that for example 0x80+0x80 at 8 bits gives 0xFF00.
- R7: With `acc_mode`=1, each lane sum is added to the destination lane at the same doubled-width position, modulo 2 to the power of that width. With `acc_mode`=0 the destination vector is ignored.
- R8: With insn[6]=0, only source bits [63:0] are used and result bits [127:64] are zero.
- R9: A request accepted at one edge appears on the output after that edge with `out_valid`=1. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R10: While `out_valid`=1 and `out_ready`=0, every output field holds its value.
- R11: During reset, `out_valid` and `out_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| insn | input | 32 | Instruction word |
| acc_mode | input | 1 | 1 selects the accumulate variant |
| src_vec | input | 128 | Source vector |
| dst_vec | input | 128 | Current destination vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_wr_en | output | 1 | Destination should be written |
| out_undef | output | 1 | Undefined-instruction flag |
| out_match | output | 1 | Word matched the encoding |
| out_quad | output | 1 | 128-bit operand form |
| out_rd_idx | output | 5 | Destination register index |
| out_rs_idx | output | 5 | Source register index |
| out_result | output | 128 | Result vector |

## Verification
Each fault has a visible effect at the outputs:
- A wrong lane slice, sign extension or size selection shows up as wrong bits in `out_result` in the cycle right after acceptance.
- An undefined-case error shows up as `out_wr_en` and `out_undef` together, or as a missed flag, in that same cycle.
- An output register that is not held under back-pressure shows up as a changed field while `out_ready` is low, on the next edge.

The bench compares `in_ready` and every output field on every cycle, so these faults are caught at once. The stimulus includes the extreme values, accumulate wraparound and each undefined case.

// File: rtl/pwadd_pkg.sv
package pwadd_pkg;
  localparam int INSN_W = 32;
  localparam int IDX_W  = 5;

  typedef enum logic [1:0] {
    SZ_B8   = 2'd0,
    SZ_B16  = 2'd1,
    SZ_B32  = 2'd2,
    SZ_RSVD = 2'd3
  } elem_sz_e;

  typedef struct packed {
    logic             match;
    logic             undef;
    logic             is_unsigned;
    logic             quad;
    elem_sz_e         esz;
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rs;
  } dec_t;
endpackage

// File: rtl/pwadd_decode.sv
module pwadd_decode
  import pwadd_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic fixed_ok;
  logic odd_reg;

  always_comb begin
    fixed_ok = (insn[31:23] == 9'b111100111) &&
               (insn[21:20] == 2'b11) &&
               (insn[17:16] == 2'b00) &&
               (insn[11:8]  == 4'b0110) &&
               (insn[4] == 1'b0);
    odd_reg  = insn[12] | insn[0];

    dec.match       = fixed_ok;
    dec.esz         = elem_sz_e'(insn[19:18]);
    dec.is_unsigned = insn[7];
    dec.quad        = insn[6];
    dec.rd          = {insn[22], insn[15:12]};
    dec.rs          = {insn[5],  insn[3:0]};
    dec.undef       = fixed_ok &&
                      ((elem_sz_e'(insn[19:18]) == SZ_RSVD) || (insn[6] && odd_reg));
  end
endmodule

// File: rtl/pwadd_lane.sv
module pwadd_lane #(
  parameter int EW = 8,
  localparam int OW = 2 * EW
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [OW-1:0] acc_in,
  input  logic          is_unsigned,
  input  logic          acc_en,
  output logic [OW-1:0] sum
);
  logic [OW-1:0] ax, bx, addend;

  always_comb begin
    ax     = is_unsigned ? {{EW{1'b0}}, a} : {{EW{a[EW-1]}}, a};
    bx     = is_unsigned ? {{EW{1'b0}}, b} : {{EW{b[EW-1]}}, b};
    addend = acc_en ? acc_in : '0;
    sum    = ax + bx + addend;
  end
endmodule

// File: rtl/pwadd_datapath.sv
module pwadd_datapath
  import pwadd_pkg::*;
#(
  parameter int VEC_W = 128,
  localparam int HALF = VEC_W / 2,
  localparam int N_SZ = 3
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  elem_sz_e         esz,
  input  logic             is_unsigned,
  input  logic             quad,
  input  logic             acc_en,
  output logic [VEC_W-1:0] result
);
  logic [VEC_W-1:0] per_sz [N_SZ];

  for (genvar s = 0; s < N_SZ; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int OW = 2 * EW;
    localparam int NL = VEC_W / OW;
    logic [VEC_W-1:0] lanes;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      pwadd_lane #(.EW(EW)) u_lane (
        .a          (src[2*i*EW +: EW]),
        .b          (src[(2*i+1)*EW +: EW]),
        .acc_in     (dst[i*OW +: OW]),
        .is_unsigned(is_unsigned),
        .acc_en     (acc_en),
        .sum        (lanes[i*OW +: OW])
      );
    end
    assign per_sz[s] = lanes;
  end

  always_comb begin
    case (esz)
      SZ_B8:   result = per_sz[0];
      SZ_B16:  result = per_sz[1];
      SZ_B32:  result = per_sz[2];
      default: result = '0;
    endcase
    if (!quad) result[VEC_W-1:HALF] = '0;
  end
endmodule

// File: rtl/pwadd_unit.sv
module pwadd_unit
  import pwadd_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic              acc_mode,
  input  logic [VEC_W-1:0]  src_vec,
  input  logic [VEC_W-1:0]  dst_vec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic              out_undef,
  output logic              out_match,
  output logic              out_quad,
  output logic [IDX_W-1:0]  out_rd_idx,
  output logic [IDX_W-1:0]  out_rs_idx,
  output logic [VEC_W-1:0]  out_result
);
  dec_t             dec;
  logic [VEC_W-1:0] dp_res;
  logic             take;
  logic             wr_ok;

  pwadd_decode u_dec (
    .insn(insn),
    .dec (dec)
  );

  pwadd_datapath #(.VEC_W(VEC_W)) u_dp (
    .src        (src_vec),
    .dst        (dst_vec),
    .esz        (dec.esz),
    .is_unsigned(dec.is_unsigned),
    .quad       (dec.quad),
    .acc_en     (acc_mode),
    .result     (dp_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign wr_ok    = dec.match && !dec.undef;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_wr_en  <= 1'b0;
      out_undef  <= 1'b0;
      out_match  <= 1'b0;
      out_quad   <= 1'b0;
      out_rd_idx <= '0;
      out_rs_idx <= '0;
      out_result <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_wr_en  <= wr_ok;
      out_undef  <= dec.undef;
      out_match  <= dec.match;
      out_quad   <= dec.quad;
      out_rd_idx <= dec.rd;
      out_rs_idx <= dec.rs;
      out_result <= wr_ok ? dp_res : '0;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pwadd_unit_chk.sv
module pwadd_unit_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_wr_en,
  input logic             out_undef,
  input logic             out_match,
  input logic             out_quad,
  input logic [4:0]       out_rd_idx,
  input logic [VEC_W-1:0] out_result
);
  localparam int HALF = VEC_W / 2;

  // R3 R4: an undefined instruction never writes
  p_undef_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_wr_en);

  // R1: a write or an undefined flag only follows a matching word
  p_flags_need_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_wr_en || out_undef) |-> out_match);

  // R8: the doubleword form leaves the upper half zero
  p_dword_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_quad |-> out_result[VEC_W-1:HALF] == '0);

  // R9: an accepted request is present on the next cycle
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: output holds while stalled
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_rd_idx) && $stable(out_wr_en) && $stable(out_undef));
endmodule

bind pwadd_unit pwadd_unit_chk #(.VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_wr_en (out_wr_en),
  .out_undef (out_undef),
  .out_match (out_match),
  .out_quad  (out_quad),
  .out_rd_idx(out_rd_idx),
  .out_result(out_result)
);

// File: tb/pwadd_unit_tb_top.sv
`timescale 1ns/1ps
module pwadd_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  insn = '0;
  logic         acc_mode = 1'b0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_vec = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic         out_wr_en, out_undef, out_match, out_quad;
  logic [4:0]   out_rd_idx, out_rs_idx;
  logic [127:0] out_result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwadd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .acc_mode(acc_mode), .src_vec(src_vec), .dst_vec(dst_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_wr_en(out_wr_en),
    .out_undef(out_undef), .out_match(out_match), .out_quad(out_quad),
    .out_rd_idx(out_rd_idx), .out_rs_idx(out_rs_idx), .out_result(out_result)
  );

  // ---------------- reference model ----------------
  bit         m_valid = 0, m_wr = 0, m_undef = 0, m_match = 0, m_quad = 0, m_acc = 0;
  bit [4:0]   m_rd = 0, m_rs = 0;
  bit [127:0] m_res = '0;
  bit [31:0]  m_insn = '0;

  function automatic bit ref_match(bit [31:0] w);
    return (w & 32'hFFB3_0F10) == 32'hF3B0_0600;
  endfunction

  function automatic bit ref_undef(bit [31:0] w);
    if (!ref_match(w)) return 0;
    if (w[19:18] == 2'b11) return 1;
    return w[6] && (w[12] || w[0]);
  endfunction

  function automatic bit [127:0] ref_calc(bit [31:0] w, bit acc, bit [127:0] s, bit [127:0] d);
    int ew = 8 << w[19:18];
    int ow = 2 * ew;
    int nl = (w[6] ? 128 : 64) / ow;
    bit [127:0] r = '0;
    for (int i = 0; i < nl; i++) begin
      longint a = 0, b = 0, dl = 0, t;
      bit [63:0] tv;
      for (int k = 0; k < ew; k++) begin
        a[k] = s[2*i*ew + k];
        b[k] = s[(2*i+1)*ew + k];
      end
      if (!w[7] && a[ew-1]) a = a - (longint'(1) << ew);
      if (!w[7] && b[ew-1]) b = b - (longint'(1) << ew);
      if (acc) for (int k = 0; k < ow; k++) dl[k] = d[i*ow + k];
      t = a + b + dl;
      tv = t;
      for (int k = 0; k < ow; k++) r[i*ow + k] = tv[k];
    end
    return r;
  endfunction

  function automatic string res_tag();
    if (!m_quad) return "R8";
    if (m_acc) return "R7";
    if (!m_insn[7]) return "R6";
    return "R5";
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h insn=%h", tag, what, act, exp, m_insn);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit mir;
      mir = !m_valid || out_ready;
      chk(in_ready === mir, "R9", "in_ready", 128'(in_ready), 128'(mir));
      chk(out_valid === m_valid, "R9 R10", "out_valid", 128'(out_valid), 128'(m_valid));
      if (m_valid) begin
        chk(out_match === m_match, "R1", "match", 128'(out_match), 128'(m_match));
        chk(out_undef === m_undef, m_insn[19:18] == 2'b11 ? "R3" : "R4", "undef",
            128'(out_undef), 128'(m_undef));
        chk(out_wr_en === m_wr, "R1", "wr_en", 128'(out_wr_en), 128'(m_wr));
        chk(out_rd_idx === m_rd && out_rs_idx === m_rs && out_quad === m_quad, "R2", "rd/rs/quad",
            {out_quad, out_rd_idx, out_rs_idx}, {m_quad, m_rd, m_rs});
        chk(out_result === m_res, m_wr ? res_tag() : "R1", "result", out_result, m_res);
      end
      if (in_valid && mir) begin
        m_valid = 1;
        m_insn  = insn;
        m_acc   = acc_mode;
        m_match = ref_match(insn);
        m_undef = ref_undef(insn);
        m_wr    = m_match && !m_undef;
        m_quad  = insn[6];
        m_rd    = {insn[22], insn[15:12]};
        m_rs    = {insn[5], insn[3:0]};
        m_res   = m_wr ? ref_calc(insn, acc_mode, src_vec, dst_vec) : '0;
      end else if (m_valid && out_ready) begin
        m_valid = 0;
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic bit [31:0] mk(bit d, bit [1:0] sz, bit [3:0] vd, bit op, bit q, bit m, bit [3:0] vm);
    return 32'hF3B0_0600 | (32'(d) << 22) | (32'(sz) << 18) | (32'(vd) << 12) |
           (32'(op) << 7) | (32'(q) << 6) | (32'(m) << 5) | 32'(vm);
  endfunction

  task automatic send(bit [31:0] w, bit acc, bit [127:0] s, bit [127:0] d);
    @(posedge clk); #1;
    in_valid = 1; insn = w; acc_mode = acc; src_vec = s; dst_vec = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  bit bp_on = 0;
  always @(posedge clk) begin
    #1;
    if (bp_on) out_ready = ($urandom % 3) != 0;
    else out_ready = 1;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    bit [127:0] s, d;
    repeat (3) @(negedge clk);
    chk(out_valid === 0 && out_wr_en === 0, "R11", "reset state",
        {out_valid, out_wr_en}, 128'(0));
    @(posedge clk); #1; rst_n = 1;

    // every size, signedness, operand width at extremes
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 2; op++)
        for (int q = 0; q < 2; q++) begin
          send(mk(1, 2'(sz), 4'h2, op[0], q[0], 1, 4'h4), 0, {16{8'h80}}, '0);
          send(mk(0, 2'(sz), 4'h6, op[0], q[0], 0, 4'h8), 0, {16{8'hFF}}, '0);
          send(mk(1, 2'(sz), 4'hA, op[0], q[0], 1, 4'hC), 0, {16{8'h7F}}, '0);
          send(mk(0, 2'(sz), 4'h0, op[0], q[0], 1, 4'h2), 0,
               128'h0123_4567_89AB_CDEF_8000_7FFF_FFFF_0001, '0);
          // accumulate wraparound
          send(mk(0, 2'(sz), 4'h4, op[0], q[0], 0, 4'h6), 1, {16{8'hFF}}, {16{8'hFF}});
          send(mk(1, 2'(sz), 4'h8, op[0], q[0], 0, 4'hE), 1, {16{8'h80}}, {8{16'h8000}});
          send(mk(1, 2'(sz), 4'h8, op[0], q[0], 0, 4'hE), 1, {16{8'h7F}}, {16{8'h7F}});
        end
    // undefined cases
    send(mk(0, 2'b11, 4'h2, 0, 0, 0, 4'h2), 0, {16{8'h11}}, '0);
    send(mk(1, 2'b11, 4'h2, 1, 1, 0, 4'h2), 1, {16{8'h11}}, '0);
    send(mk(0, 2'b00, 4'h3, 1, 1, 0, 4'h2), 0, {16{8'h22}}, '0);
    send(mk(0, 2'b01, 4'h2, 0, 1, 0, 4'h5), 1, {16{8'h22}}, '0);
    send(mk(0, 2'b10, 4'h3, 0, 0, 1, 4'h5), 0, {16{8'h33}}, '0);
    // non-matching words
    send(mk(0, 2'b00, 4'h2, 0, 0, 0, 4'h2) | 32'h10, 0, {16{8'h44}}, '0);
    send(mk(0, 2'b00, 4'h2, 0, 0, 0, 4'h2) ^ 32'h0001_0000, 0, {16{8'h44}}, '0);
    send(mk(0, 2'b00, 4'h2, 0, 0, 0, 4'h2) ^ 32'h0000_0100, 0, {16{8'h44}}, '0);

    // random traffic under back-pressure
    bp_on = 1;
    for (int n = 0; n < 300; n++) begin
      bit [31:0] w;
      w = mk($urandom % 2, 2'($urandom), 4'($urandom), $urandom % 2, $urandom % 2,
             $urandom % 2, 4'($urandom));
      if (($urandom % 10) == 0) w = w ^ (32'h1 << ($urandom % 32));
      s = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom};
      send(w, $urandom % 2, s, d);
    end
    bp_on = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule